// File: doc/BRIEF.md
# Cache-Block Operation Permission Checker

This block holds three environment-configuration registers, one each for the machine, hypervisor and supervisor levels. It judges whether a cache-block management instruction (invalidate, clean/flush) or a cache-block zeroing instruction may run at the current privilege level. Software writes and reads the registers through a plain CSR port addressed by the 12-bit CSR number. Writes are captured on the next rising clock edge. Reads are combinational.

The core's decode stage presents the current privilege level, a flag that says whether virtualisation is on, and a one-hot operation class. In the same cycle the block returns exactly one of three results: pass, virtual-instruction fault or illegal-instruction fault. The virtual-instruction fault is evaluated first and suppresses the illegal-instruction fault. All outputs come from combinational logic on the registered configuration, so no request is buffered. The block has no streaming interface, and no pin carries back-pressure.

Top module: `cbo_perm_check`

## Requirements
- R1: The supervisor register answers at CSR number 0x10A, the machine register at 0x30A and the hypervisor register at 0x60A. A read at one of these addresses returns that register and drives `csr_hit` high. A read at any other address returns zero with `csr_hit` low, and a write there changes no register.
- R2: Each register stores only bits 7:4: the invalidate enable in bits 5:4, the clean/flush enable in bit 6 and the zero enable in bit 7. Every other bit reads back as zero whatever was written.
- R3: All three registers read zero after reset. A write shows up on `csr_rdata` and in the permission result only after the next rising clock edge.
- R4: `op_sel` bit 0 selects invalidate, bit 1 selects clean/flush and bit 2 selects zero. The invalidate enable counts as set when its 2-bit field is non-zero.
- R5: With `virt_on` high, `vinst_fault` is raised if the privilege is below 2 and the selected hypervisor enable is clear, or if the privilege is below 1 and the selected supervisor enable is clear. Privilege is encoded U=0, S=1, M=3.
- R6: `illegal_fault` is raised if the privilege is below 3 and the selected machine enable is clear, or if the privilege is below 1 and the selected supervisor enable is clear. It is raised only when `vinst_fault` is not raised.
- R7: At most one of `vinst_fault` and `illegal_fault` is high in any cycle. A virtual-instruction condition always wins.
- R8: `op_pass` is high only when `op_sel` is one-hot and neither fault is raised. If `op_sel` is not one-hot, all three result outputs are low.
- R9: At machine privilege (3), any one-hot operation passes, whatever the register contents and virtualisation flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_we | input | 1 | CSR write strobe |
| csr_addr | input | 12 | CSR number for read and write |
| csr_wdata | input | XLEN | CSR write data |
| csr_rdata | output | XLEN | CSR read data (combinational) |
| csr_hit | output | 1 | Address matches one of the three registers |
| priv_lvl | input | 2 | Current privilege level |
| virt_on | input | 1 | Virtualisation enabled |
| op_sel | input | 3 | One-hot operation class |
| op_pass | output | 1 | Operation may execute |
| vinst_fault | output | 1 | Virtual-instruction fault |
| illegal_fault | output | 1 | Illegal-instruction fault |

## Verification
The bench goes after the priority case in which both the hypervisor and the machine enables are clear at U or S privilege with virtualisation on. A design that checked illegal first would report the wrong fault there. The bench loads the invalidate field with each non-zero value alone, so a design that tested only one bit of the field would fault on half of them. It also covers writes of all ones, which must read back only the four implemented bits, and writes to a neighbouring address, which must leave every register alone. Random register contents, privileges (including the reserved level 2) and multi-hot operation codes catch an enable taken from the wrong level or wrong bit, and a pass raised on an invalid code.

// File: rtl/cbo_perm_pkg.sv
package cbo_perm_pkg;
  localparam logic [11:0] CSR_SUP_CFG = 12'h10A;
  localparam logic [11:0] CSR_MCH_CFG = 12'h30A;
  localparam logic [11:0] CSR_HYP_CFG = 12'h60A;

  localparam int INV_LO  = 4;
  localparam int INV_HI  = 5;
  localparam int CLN_BIT = 6;
  localparam int ZRO_BIT = 7;
  localparam int FIELD_LO = INV_LO;
  localparam int FIELD_HI = ZRO_BIT;

  localparam int NUM_LVL = 3;
  localparam int LVL_SUP = 0;
  localparam int LVL_MCH = 1;
  localparam int LVL_HYP = 2;

  localparam int NUM_OPS = 3;
  localparam int OP_INV  = 0;
  localparam int OP_CLN  = 1;
  localparam int OP_ZRO  = 2;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_H = 2'd2;
  localparam logic [1:0] PRIV_M = 2'd3;

  function automatic logic [11:0] lvl_addr(input int lvl);
    case (lvl)
      LVL_SUP: lvl_addr = CSR_SUP_CFG;
      LVL_MCH: lvl_addr = CSR_MCH_CFG;
      default: lvl_addr = CSR_HYP_CFG;
    endcase
  endfunction
endpackage

// File: rtl/cbo_cfg_regs.sv
module cbo_cfg_regs
  import cbo_perm_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            we,
  input  logic [11:0]                     addr,
  input  logic [XLEN-1:0]                 wdata,
  output logic [XLEN-1:0]                 rdata,
  output logic                            hit,
  output logic [NUM_LVL-1:0][FIELD_HI:FIELD_LO] fields
);
  localparam int FW = FIELD_HI - FIELD_LO + 1;

  logic [NUM_LVL-1:0] sel;
  logic [NUM_LVL-1:0][FW-1:0] store_q;

  for (genvar l = 0; l < NUM_LVL; l++) begin : g_lvl
    localparam logic [11:0] MY_ADDR = lvl_addr(l);
    assign sel[l] = (addr == MY_ADDR);

    always_ff @(posedge clk) begin
      if (!rst_n) store_q[l] <= '0;
      else if (we && sel[l]) store_q[l] <= wdata[FIELD_HI:FIELD_LO];
    end

    assign fields[l] = store_q[l];

    // R3: a write lands on the next edge with only the implemented bits
    p_write_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (we && sel[l]) |=> (fields[l] == $past(wdata[FIELD_HI:FIELD_LO])));
    // R1: other addresses leave the register unchanged
    p_no_stray_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !(we && sel[l]) |=> $stable(fields[l]));
  end

  always_comb begin
    rdata = '0;
    for (int l = 0; l < NUM_LVL; l++)
      if (sel[l]) rdata[FIELD_HI:FIELD_LO] = store_q[l];
  end

  assign hit = |sel;

  // R1: the three addresses are distinct, so at most one matches
  p_one_match_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));
endmodule

// File: rtl/cbo_enable_select.sv
module cbo_enable_select
  import cbo_perm_pkg::*;
(
  input  logic [NUM_LVL-1:0][FIELD_HI:FIELD_LO] fields,
  input  logic [NUM_OPS-1:0]                    op_sel,
  output logic [NUM_LVL-1:0]                    lvl_en,
  output logic                                  op_valid
);
  for (genvar l = 0; l < NUM_LVL; l++) begin : g_en
    logic inv_on;
    assign inv_on    = |fields[l][INV_HI:INV_LO];
    assign lvl_en[l] = (op_sel[OP_INV] & inv_on)
                     | (op_sel[OP_CLN] & fields[l][CLN_BIT])
                     | (op_sel[OP_ZRO] & fields[l][ZRO_BIT]);
  end

  assign op_valid = ($countones(op_sel) == 1);
endmodule

// File: rtl/cbo_fault_eval.sv
module cbo_fault_eval
  import cbo_perm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         priv_lvl,
  input  logic               virt_on,
  input  logic [NUM_LVL-1:0] lvl_en,
  input  logic               op_valid,
  output logic               op_pass,
  output logic               vinst_fault,
  output logic               illegal_fault
);
  logic below_h, below_s, below_m;
  logic v_cond, i_cond;

  assign below_h = (priv_lvl < PRIV_H);
  assign below_s = (priv_lvl < PRIV_S);
  assign below_m = (priv_lvl < PRIV_M);

  assign v_cond = virt_on && ((below_h && !lvl_en[LVL_HYP]) ||
                              (below_s && !lvl_en[LVL_SUP]));
  assign i_cond = (below_m && !lvl_en[LVL_MCH]) ||
                  (below_s && !lvl_en[LVL_SUP]);

  always_comb begin
    op_pass       = 1'b0;
    vinst_fault   = 1'b0;
    illegal_fault = 1'b0;
    if (op_valid) begin
      if (v_cond)      vinst_fault   = 1'b1;
      else if (i_cond) illegal_fault = 1'b1;
      else             op_pass       = 1'b1;
    end
  end

  // R7: never two faults at once
  p_single_fault_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({vinst_fault, illegal_fault}));
  // R8: pass excludes both faults
  p_pass_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
    op_pass |-> !(vinst_fault || illegal_fault));
  // R9: machine level always passes a valid operation
  p_mach_pass_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && priv_lvl == PRIV_M) |-> op_pass);
  // R5: a virtual fault needs virtualisation on
  p_vfault_virt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    vinst_fault |-> virt_on);
endmodule

// File: rtl/cbo_perm_check.sv
module cbo_perm_check
  import cbo_perm_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            csr_we,
  input  logic [11:0]     csr_addr,
  input  logic [XLEN-1:0] csr_wdata,
  output logic [XLEN-1:0] csr_rdata,
  output logic            csr_hit,
  input  logic [1:0]      priv_lvl,
  input  logic            virt_on,
  input  logic [2:0]      op_sel,
  output logic            op_pass,
  output logic            vinst_fault,
  output logic            illegal_fault
);
  logic [NUM_LVL-1:0][FIELD_HI:FIELD_LO] fields;
  logic [NUM_LVL-1:0] lvl_en;
  logic               op_valid;

  cbo_cfg_regs #(.XLEN(XLEN)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(csr_we), .addr(csr_addr),
    .wdata(csr_wdata), .rdata(csr_rdata), .hit(csr_hit), .fields(fields)
  );

  cbo_enable_select u_sel (
    .fields(fields), .op_sel(op_sel), .lvl_en(lvl_en), .op_valid(op_valid)
  );

  cbo_fault_eval u_eval (
    .clk(clk), .rst_n(rst_n), .priv_lvl(priv_lvl), .virt_on(virt_on),
    .lvl_en(lvl_en), .op_valid(op_valid), .op_pass(op_pass),
    .vinst_fault(vinst_fault), .illegal_fault(illegal_fault)
  );

  // R8: an invalid operation code produces no result
  p_invalid_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(op_sel) != 1) |-> !(op_pass || vinst_fault || illegal_fault));
  // R2: unimplemented bits always read zero
  p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rdata[XLEN-1:FIELD_HI+1] == '0 && csr_rdata[FIELD_LO-1:0] == '0);
endmodule

// File: tb/cbo_perm_check_bench.sv
module cbo_perm_check_bench;
  localparam int XLEN = 64;
  localparam logic [63:0] MASK = 64'hF0;

  logic clk = 0;
  logic rst_n = 0;
  logic csr_we = 0;
  logic [11:0] csr_addr = '0;
  logic [XLEN-1:0] csr_wdata = '0;
  logic [XLEN-1:0] csr_rdata;
  logic csr_hit;
  logic [1:0] priv_lvl = 0;
  logic virt_on = 0;
  logic [2:0] op_sel = 0;
  logic op_pass, vinst_fault, illegal_fault;

  int n_chk = 0;
  int n_fail = 0;
  logic [63:0] m_s = 0, m_m = 0, m_h = 0;

  always #4 clk = ~clk;

  cbo_perm_check #(.XLEN(XLEN)) u_cbo_perm_check (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .csr_hit(csr_hit),
    .priv_lvl(priv_lvl), .virt_on(virt_on), .op_sel(op_sel),
    .op_pass(op_pass), .vinst_fault(vinst_fault), .illegal_fault(illegal_fault)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic en_of(input logic [63:0] r, input logic [2:0] op);
    return (op[0] && (r[5:4] != 0)) || (op[1] && r[6]) || (op[2] && r[7]);
  endfunction

  function automatic logic [2:0] expect_out(input logic [1:0] pv, input logic vt,
                                            input logic [2:0] op);
    logic em, eh, es, vf, il;
    if (!(op == 3'b001 || op == 3'b010 || op == 3'b100)) return 3'b000;
    em = en_of(m_m, op); eh = en_of(m_h, op); es = en_of(m_s, op);
    vf = vt && ((pv < 2 && !eh) || (pv < 1 && !es));
    il = !vf && ((pv < 3 && !em) || (pv < 1 && !es));
    return {!vf && !il, vf, il};
  endfunction

  function automatic logic [63:0] model_read(input logic [11:0] a);
    case (a)
      12'h10A: return m_s;
      12'h30A: return m_m;
      12'h60A: return m_h;
      default: return 64'h0;
    endcase
  endfunction

  task automatic csr_write(input logic [11:0] a, input logic [63:0] d);
    @(negedge clk);
    csr_we = 1; csr_addr = a; csr_wdata = d;
    @(posedge clk);
    #1 csr_we = 0;
    case (a)
      12'h10A: m_s = d & MASK;
      12'h30A: m_m = d & MASK;
      12'h60A: m_h = d & MASK;
      default: ;
    endcase
  endtask

  task automatic csr_check(input string req, input logic [11:0] a);
    @(negedge clk);
    csr_addr = a;
    #2;
    check(req, csr_rdata, model_read(a));
    check(req, {63'b0, csr_hit}, {63'b0, (a == 12'h10A || a == 12'h30A || a == 12'h60A)});
  endtask

  task automatic op_check(input string req, input logic [1:0] pv, input logic vt,
                          input logic [2:0] op);
    @(negedge clk);
    priv_lvl = pv; virt_on = vt; op_sel = op;
    #2;
    check(req, {61'b0, op_pass, vinst_fault, illegal_fault}, {61'b0, expect_out(pv, vt, op)});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R3: reset state
    csr_check("R3 reset sup", 12'h10A);
    csr_check("R3 reset mch", 12'h30A);
    csr_check("R3 reset hyp", 12'h60A);
    // R6: all clear at U without virtualisation -> illegal
    op_check("R6 U all clear", 2'd0, 1'b0, 3'b001);
    // R7: priority, virtual first
    op_check("R7 U virt all clear", 2'd0, 1'b1, 3'b100);
    op_check("R7 S virt all clear", 2'd1, 1'b1, 3'b010);
    // R9: M always passes
    op_check("R9 M all clear", 2'd3, 1'b1, 3'b001);
    // R8: invalid codes
    op_check("R8 zero op", 2'd0, 1'b1, 3'b000);
    op_check("R8 multi op", 2'd3, 1'b0, 3'b011);

    // R2: write all ones, only bits 7:4 stick
    csr_write(12'h30A, '1);
    csr_check("R2 mch ones", 12'h30A);
    check("R2 mch value", csr_rdata, 64'hF0);

    // R3: write visible only after the edge
    @(negedge clk);
    csr_we = 1; csr_addr = 12'h10A; csr_wdata = 64'h10;
    #2 check("R3 before edge", csr_rdata, 64'h0);
    @(posedge clk);
    #1 csr_we = 0; m_s = 64'h10;
    #1 check("R3 after edge", csr_rdata, 64'h10);

    // R4: invalidate field values 01 and 10 both enable
    op_check("R4 inval 01 U", 2'd0, 1'b0, 3'b001);
    op_check("R4 clean off U", 2'd0, 1'b0, 3'b010);
    csr_write(12'h10A, 64'h20);
    op_check("R4 inval 10 U", 2'd0, 1'b0, 3'b001);
    // R5: hypervisor clear with virt on at S
    op_check("R5 S virt hyp clear", 2'd1, 1'b1, 3'b001);
    csr_write(12'h60A, 64'h30);
    op_check("R5 S virt hyp set", 2'd1, 1'b1, 3'b001);
    op_check("R5 U virt all set", 2'd0, 1'b1, 3'b001);

    // R1: neighbouring address ignored
    csr_write(12'h30B, 64'h0);
    csr_check("R1 stray addr", 12'h30B);
    csr_check("R1 mch kept", 12'h30A);
    op_check("R1 zero still ok", 2'd1, 1'b0, 3'b100);

    // random phase
    for (int i = 0; i < 3000; i++) begin
      int k;
      k = $urandom_range(0, 9);
      if (k < 3) begin
        logic [11:0] a;
        case ($urandom_range(0, 3))
          0: a = 12'h10A;
          1: a = 12'h30A;
          2: a = 12'h60A;
          default: a = 12'($urandom);
        endcase
        csr_write(a, {$urandom, $urandom});
        csr_check("R1 R2 random read", a);
      end else begin
        op_check("R5 R6 R7 R8 random op", 2'($urandom), 1'($urandom), 3'($urandom));
      end
    end

    $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule